// File: doc/BRIEF.md
# Boost LED Driver Fault Supervisor

This block gathers the digital fault flags of a multi-channel LED boost driver and decides, per fault type, whether the driver is latched off or recovers by itself. A mode input (`auto_mode_i`) picks the policy. When it is low, almost every fault latches. When it is high, most faults retry. Some faults always latch. An output overvoltage in retry mode does not stop the converter. It removes the strings that are below regulation from the control loop, and the converter keeps running.

Every condition arrives as a synchronous logic level on the system clock. The block drives four outputs: a shutdown request to the converter, an active-low fault pin drive, a one-cycle request to re-enter soft start, and a per-channel disable mask. A fault pin value of 1 means the pin is released (high impedance outside this block), and 0 means it is pulled low. Undervoltage acts within the same cycle. Every other fault reaches the outputs one clock edge after it is sampled.

Top module: `fault_supervisor`

## Requirements
- R1: During and right after reset, with enable low, `shdn_o`=1, `fault_n_o`=1, `ss_restart_o`=0 and `ch_disable_o`=0. With enable high and no fault, `shdn_o` goes to 0 after one edge.
- R2: With `auto_mode_i`=0, each of output overvoltage, compensation overcurrent, overtemperature and soft-start timeout sets a latch one edge after it is sampled. The latch gives `shdn_o`=1 and `fault_n_o`=0, and it holds after the flag drops.
- R3: A switch-node overvoltage, or any bit of `short_i`, latches the driver off in the same way under either mode level.
- R4: A latched fault clears only on an edge where `en_i` is low or `uv_i` is high. Once it has cleared and enable is high again, `shdn_o` returns to 0.
- R5: While `uv_i`=1, `shdn_o`=1 and `fault_n_o`=0 in that same cycle. Undervoltage is never held after it goes away.
- R6: With `auto_mode_i`=1, an output overvoltage does not shut down. Instead, every bit set in `lowreg_i` is ORed into `ch_disable_o` (bit i = channel i) one edge later. Mask bits accumulate and persist.
- R7: With `auto_mode_i`=1, each cycle of overcurrent gives a one-cycle `ss_restart_o`=1 one edge later, with `shdn_o` staying 0.
- R8: With `auto_mode_i`=1, overtemperature holds `shdn_o`=1 and `fault_n_o`=0 from the next edge until the edge after `cool_i` is seen high. Normal operation then resumes without any toggle of enable.
- R9: With `auto_mode_i`=1, a soft-start timeout has no effect on any output.
- R10: `fault_n_o` is 0 exactly while undervoltage, a latch, an overtemperature hold or a restart pulse is active. It is 1 otherwise, including while enable is low.
- R11: An edge with `en_i` low clears `ch_disable_o` to 0.
- R12: When a latching cause arrives in the same cycle as an overcurrent or overvoltage in auto mode, the latch wins: no `ss_restart_o` pulse and no mask update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Driver enable; low clears latches and mask |
| auto_mode_i | input | 1 | 0 = latch policy, 1 = auto-restart policy |
| uv_i | input | 1 | Input undervoltage |
| ovp_i | input | 1 | Output overvoltage |
| sw_ovp_i | input | 1 | Switch-node overvoltage (open diode) |
| ocp_i | input | 1 | Compensation overcurrent |
| hot_i | input | 1 | Overtemperature |
| cool_i | input | 1 | Junction back below lower threshold |
| ss_timeout_i | input | 1 | Soft-start timeout |
| short_i | input | N_CH | Per-channel shorted string |
| lowreg_i | input | N_CH | Per-channel below regulation |
| shdn_o | output | 1 | Shutdown request |
| fault_n_o | output | 1 | Fault pin drive, 0 = pull low |
| ss_restart_o | output | 1 | One-cycle soft-start re-entry request |
| ch_disable_o | output | N_CH | Channel disable mask |

## Verification
A stuck or lost latch shows at the ports one edge after the fault is sampled. It appears as `shdn_o` low when it should be high, or as `shdn_o` staying high after an enable toggle. A wrong mask bit shows on `ch_disable_o` one edge after the overvoltage, and again after the flag drops, which is how persistence is seen. A wrong priority decision shows as a stray restart pulse, or a mask change, in the cycle after a combined fault. A wrong overtemperature hold shows as shutdown ending early, before `cool_i`, or not ending one edge after it.

// File: rtl/fsup_pkg.sv
package fsup_pkg;
  typedef struct packed {
    logic ovp;
    logic sw_ovp;
    logic ocp;
    logic hot;
    logic ss_to;
  } fsup_flags_t;
endpackage

// File: rtl/fsup_latch.sv
module fsup_latch #(
  parameter int N_CH = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 uv,
  input  logic                 auto_mode,
  input  fsup_pkg::fsup_flags_t flags,
  input  logic [N_CH-1:0]      shorts,
  output logic                 latch_now,
  output logic                 latch_q
);
  logic always_latch_c, mode_latch_c;

  assign always_latch_c = flags.sw_ovp | (|shorts);
  assign mode_latch_c   = ~auto_mode & (flags.ovp | flags.ocp | flags.hot | flags.ss_to);
  assign latch_now      = en & ~uv & (always_latch_c | mode_latch_c);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          latch_q <= 1'b0;
    else if (!en || uv)  latch_q <= 1'b0;
    else if (latch_now)  latch_q <= 1'b1;
  end
endmodule

// File: rtl/fsup_mask.sv
module fsup_mask #(
  parameter int N_CH = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            arm,
  input  logic [N_CH-1:0] lowreg,
  output logic [N_CH-1:0] mask
);
  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 mask[i] <= 1'b0;
      else if (!en)               mask[i] <= 1'b0;
      else if (arm && lowreg[i])  mask[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/fsup_retry.sv
module fsup_retry (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic uv,
  input  logic auto_mode,
  input  logic ocp,
  input  logic hot,
  input  logic cool,
  input  logic block,
  output logic hot_hold_q,
  output logic ss_q
);
  logic run_ok;
  assign run_ok = en & ~uv & auto_mode & ~block;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hot_hold_q <= 1'b0;
      ss_q       <= 1'b0;
    end else begin
      if (!en || uv || cool)     hot_hold_q <= 1'b0;
      else if (run_ok && hot)    hot_hold_q <= 1'b1;
      ss_q <= run_ok & ocp & ~hot_hold_q;
    end
  end
endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor #(
  parameter int N_CH = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_i,
  input  logic            auto_mode_i,
  input  logic            uv_i,
  input  logic            ovp_i,
  input  logic            sw_ovp_i,
  input  logic            ocp_i,
  input  logic            hot_i,
  input  logic            cool_i,
  input  logic            ss_timeout_i,
  input  logic [N_CH-1:0] short_i,
  input  logic [N_CH-1:0] lowreg_i,
  output logic            shdn_o,
  output logic            fault_n_o,
  output logic            ss_restart_o,
  output logic [N_CH-1:0] ch_disable_o
);
  import fsup_pkg::*;

  fsup_flags_t flags;
  logic latch_now, latch_q, hot_hold_q, ss_q, blocked, mask_arm;

  assign flags = '{ovp: ovp_i, sw_ovp: sw_ovp_i, ocp: ocp_i, hot: hot_i, ss_to: ss_timeout_i};

  fsup_latch #(.N_CH(N_CH)) u_latch (
    .clk(clk), .rst_n(rst_n), .en(en_i), .uv(uv_i), .auto_mode(auto_mode_i),
    .flags(flags), .shorts(short_i), .latch_now(latch_now), .latch_q(latch_q)
  );

  assign blocked  = latch_now | latch_q;
  assign mask_arm = en_i & ~uv_i & auto_mode_i & ovp_i & ~blocked;

  fsup_mask #(.N_CH(N_CH)) u_mask (
    .clk(clk), .rst_n(rst_n), .en(en_i), .arm(mask_arm),
    .lowreg(lowreg_i), .mask(ch_disable_o)
  );

  fsup_retry u_retry (
    .clk(clk), .rst_n(rst_n), .en(en_i), .uv(uv_i), .auto_mode(auto_mode_i),
    .ocp(ocp_i), .hot(hot_i), .cool(cool_i), .block(blocked),
    .hot_hold_q(hot_hold_q), .ss_q(ss_q)
  );

  assign shdn_o       = ~en_i | uv_i | latch_q | hot_hold_q;
  assign fault_n_o    = ~(uv_i | latch_q | hot_hold_q | ss_q);
  assign ss_restart_o = ss_q;
endmodule

// File: rtl/fsup_chk.sv
module fsup_chk #(
  parameter int N_CH = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            en_i,
  input logic            auto_mode_i,
  input logic            uv_i,
  input logic            ocp_i,
  input logic            sw_ovp_i,
  input logic [N_CH-1:0] short_i,
  input logic            shdn_o,
  input logic            fault_n_o,
  input logic            ss_restart_o,
  input logic [N_CH-1:0] ch_disable_o
);
  // R3
  always_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !uv_i && (sw_ovp_i || (|short_i))) |=> shdn_o);

  // R5
  uv_shutdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uv_i |-> (shdn_o && !fault_n_o));

  // R7
  restart_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ss_restart_o |-> $past(ocp_i && auto_mode_i && en_i));

  // R11
  mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (ch_disable_o == '0));

  // R6
  mask_persist_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en_i) |-> ((ch_disable_o & $past(ch_disable_o)) == $past(ch_disable_o)));

  // R10
  fault_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_n_o |-> (uv_i || shdn_o || ss_restart_o));
endmodule

bind fault_supervisor fsup_chk #(.N_CH(N_CH)) chk_i (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .auto_mode_i(auto_mode_i), .uv_i(uv_i),
  .ocp_i(ocp_i), .sw_ovp_i(sw_ovp_i), .short_i(short_i), .shdn_o(shdn_o),
  .fault_n_o(fault_n_o), .ss_restart_o(ss_restart_o), .ch_disable_o(ch_disable_o)
);

// File: tb/fault_supervisor_tb_top.sv
`timescale 1ns/1ps
module fault_supervisor_tb_top;
  localparam int N = 6;
  logic clk = 1'b0, rst_n = 1'b0;
  logic en_i = 0, auto_mode_i = 0, uv_i = 0, ovp_i = 0, sw_ovp_i = 0, ocp_i = 0;
  logic hot_i = 0, cool_i = 0, ss_timeout_i = 0;
  logic [N-1:0] short_i = '0, lowreg_i = '0;
  logic shdn_o, fault_n_o, ss_restart_o;
  logic [N-1:0] ch_disable_o;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fault_supervisor #(.N_CH(N)) dut_i (.*);

  task automatic step(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(string req, string what, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic quiet();
    ovp_i = 0; sw_ovp_i = 0; ocp_i = 0; hot_i = 0; cool_i = 0;
    ss_timeout_i = 0; short_i = '0; lowreg_i = '0; uv_i = 0;
  endtask

  task automatic toggle_en();
    quiet(); en_i = 0; step(); en_i = 1; step();
  endtask

  task automatic t_reset();
    #1;
    chk("R1", "shdn in reset", {5'b0, shdn_o}, 6'd1);
    chk("R1", "fault_n in reset", {5'b0, fault_n_o}, 6'd1);
    chk("R1", "mask in reset", ch_disable_o, '0);
    chk("R1", "ss in reset", {5'b0, ss_restart_o}, 6'd0);
    @(negedge clk); rst_n = 1; step();
    en_i = 1; step();
    chk("R1", "shdn after enable", {5'b0, shdn_o}, 6'd0);
    chk("R10", "fault_n idle", {5'b0, fault_n_o}, 6'd1);
  endtask

  task automatic t_mode_low_latch(int which);
    auto_mode_i = 0;
    case (which)
      0: ovp_i = 1;
      1: ocp_i = 1;
      2: hot_i = 1;
      default: ss_timeout_i = 1;
    endcase
    step(); quiet(); step(2);
    chk("R2", $sformatf("latched shdn type %0d", which), {5'b0, shdn_o}, 6'd1);
    chk("R2", $sformatf("latched fault_n type %0d", which), {5'b0, fault_n_o}, 6'd0);
    chk("R2", "no restart pulse", {5'b0, ss_restart_o}, 6'd0);
    toggle_en();
    chk("R4", "cleared by enable low", {5'b0, shdn_o}, 6'd0);
  endtask

  task automatic t_always_latch(bit m);
    auto_mode_i = m;
    sw_ovp_i = 1; step(); quiet(); step();
    chk("R3", $sformatf("sw_ovp mode %0d", m), {5'b0, shdn_o}, 6'd1);
    toggle_en();
    short_i = 6'b001000; step(); quiet(); step();
    chk("R3", $sformatf("short mode %0d", m), {5'b0, shdn_o}, 6'd1);
    chk("R10", "fault pin during latch", {5'b0, fault_n_o}, 6'd0);
    toggle_en();
  endtask

  task automatic t_uv();
    auto_mode_i = 0; ovp_i = 1; step(); quiet(); step();
    chk("R4", "latch holds with enable high", {5'b0, shdn_o}, 6'd1);
    uv_i = 1; #1;
    chk("R5", "uv shdn", {5'b0, shdn_o}, 6'd1);
    chk("R5", "uv fault_n", {5'b0, fault_n_o}, 6'd0);
    step(); uv_i = 0; #1;
    chk("R5", "uv not held, latch cleared", {5'b0, shdn_o}, 6'd0);
    chk("R10", "fault_n released after uv", {5'b0, fault_n_o}, 6'd1);
    step();
  endtask

  task automatic t_ovp_mask();
    auto_mode_i = 1; ovp_i = 1; lowreg_i = 6'b000101; step();
    chk("R6", "first mask", ch_disable_o, 6'b000101);
    chk("R6", "no shutdown", {5'b0, shdn_o}, 6'd0);
    ovp_i = 0; lowreg_i = 6'b110000; step();
    chk("R6", "no update without ovp", ch_disable_o, 6'b000101);
    ovp_i = 1; lowreg_i = 6'b010000; step(); quiet(); step();
    chk("R6", "accumulated and persisted", ch_disable_o, 6'b010101);
    en_i = 0; step(); en_i = 1; #1;
    chk("R11", "mask cleared by enable low", ch_disable_o, '0);
    step();
  endtask

  task automatic t_ocp_retry();
    auto_mode_i = 1; ocp_i = 1; step();
    chk("R7", "restart pulse", {5'b0, ss_restart_o}, 6'd1);
    chk("R7", "no shutdown", {5'b0, shdn_o}, 6'd0);
    chk("R10", "fault pin on pulse", {5'b0, fault_n_o}, 6'd0);
    ocp_i = 0; step();
    chk("R7", "pulse ends", {5'b0, ss_restart_o}, 6'd0);
    chk("R10", "fault pin released", {5'b0, fault_n_o}, 6'd1);
  endtask

  task automatic t_hot_retry();
    auto_mode_i = 1; hot_i = 1; step(); hot_i = 0; step(3);
    chk("R8", "hold until cool", {5'b0, shdn_o}, 6'd1);
    chk("R8", "fault_n in hold", {5'b0, fault_n_o}, 6'd0);
    cool_i = 1; step(); cool_i = 0;
    chk("R8", "auto resume", {5'b0, shdn_o}, 6'd0);
    chk("R8", "fault_n after resume", {5'b0, fault_n_o}, 6'd1);
  endtask

  task automatic t_timeout_ignored();
    auto_mode_i = 1; ss_timeout_i = 1; step(); ss_timeout_i = 0; step();
    chk("R9", "timeout shdn", {5'b0, shdn_o}, 6'd0);
    chk("R9", "timeout fault_n", {5'b0, fault_n_o}, 6'd1);
    chk("R9", "timeout mask", ch_disable_o, '0);
  endtask

  task automatic t_priority();
    auto_mode_i = 1; short_i = 6'b000001; ocp_i = 1; ovp_i = 1; lowreg_i = 6'b100000;
    step();
    chk("R12", "no pulse under latch", {5'b0, ss_restart_o}, 6'd0);
    chk("R12", "no mask under latch", ch_disable_o, '0);
    chk("R12", "latched shutdown", {5'b0, shdn_o}, 6'd1);
    toggle_en();
  endtask

  initial begin
    t_reset();
    for (int w = 0; w < 4; w++) t_mode_low_latch(w);
    t_always_latch(0);
    t_always_latch(1);
    t_uv();
    t_ovp_mask();
    t_ocp_retry();
    t_hot_retry();
    t_timeout_ignored();
    t_priority();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule